// File: doc/BRIEF.md
# SM3 Message Expansion Unit

This unit turns one 512-bit message block into the stream of expanded words that the SM3 compression rounds consume. Each round needs two values: the expanded word W[j], which enters the E-side sum, and the mixed word W'[j] = W[j] XOR W[j+4], which enters the A-side sum. The unit presents one (W, W') pair per round, together with the round index, for rounds 0 through 63.

The block is split into sixteen big-endian 32-bit words and loaded into a sixteen-entry sliding window. Each time a pair is taken, the window shifts by one. The word that enters at the tail is produced from five window taps through the P1 permutation, P1(x) = x ^ rotl(x,15) ^ rotl(x,23). The 68 expanded words are therefore never stored together. Because the window always holds words j through j+15, the word W[j+4] that W'[j] needs is already present. Padding, length encoding and the compression arithmetic sit outside this block.

A block is offered on a valid/ready pair. The pairs leave on a valid/ready pair with the round index beside them. A new block is accepted only once the 64th pair of the previous block has been taken.

Top module: `sm3x_msg_expand`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the unit clears its window and round counter. After that edge `out_valid` is 0, `in_ready` is 1 and `out_round` is 0.
- R2: When idle, `in_ready` is 1. A block is accepted on a rising edge where `in_valid` and `in_ready` are both 1. From the next cycle on, `out_valid` is 1 and `out_round` is 0.
- R3: The block is packed big-endian. Word i (0..15) is `in_block[511-32*i -: 32]`, so byte 0 sits in `in_block[511:504]` and becomes the most significant byte of W[0]. For rounds 0..15, `out_w` equals word `out_round`.
- R4: For rounds 16..63, `out_w` equals W[j] = P1(W[j-16] ^ W[j-9] ^ rotl(W[j-3],15)) ^ rotl(W[j-13],7) ^ W[j-6], with P1(x) = x ^ rotl(x,15) ^ rotl(x,23).
- R5: For every round j from 0 to 63, `out_wp` equals W[j] ^ W[j+4]. W[64..67] are produced by the same recurrence.
- R6: The pair for a round is taken on an edge where `out_valid` and `out_ready` are both 1. After each such edge (except the last), `out_round` has risen by one, so the rounds appear in order 0..63 with no gap or repeat.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_w`, `out_wp` and `out_round` hold their values and `out_valid` stays 1.
- R8: Exactly 64 pairs are emitted per block. After the edge that takes round 63, `out_valid` is 0 and `in_ready` is 1.
- R9: While a block is being emitted, `in_ready` is 0, and `in_valid` together with `in_block` have no effect: the rest of the stream still follows the block that was accepted.
- R10: Reset during emission abandons the block. After the reset edge `out_valid` is 0, and a fresh block that is then offered streams correctly from round 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A message block is offered |
| in_ready | output | 1 | Unit is idle and will take a block |
| in_block | input | 512 | Message block, byte 0 in bits 511:504 |
| out_valid | output | 1 | A (W, W') pair is presented |
| out_ready | input | 1 | Consumer takes the presented pair |
| out_round | output | 6 | Round index of the presented pair |
| out_w | output | 32 | Expanded word W[j] |
| out_wp | output | 32 | Mixed word W[j] ^ W[j+4] |

## Verification
The assertions check the protocol on every cycle:
- the reset state;
- the start of a stream after an accepted block, and that the first word is the top 32 bits of that block;
- the round index stepping by one per taken pair;
- that all outputs hold under backpressure;
- the return to idle after round 63.

They also check on every cycle that each mixed word equals the expanded word four rounds later XOR the current word, using a four-deep history.

Only the bench's scenarios can show that the recurrence values themselves are right. It compares them against an independent model over several blocks, with and without stalls, with a block pushed while busy, and with reset in the middle of a stream.

// File: rtl/sm3x_pkg.sv
// Package: shared word type and the SM3 expansion arithmetic.
// Assumes 32-bit words; rotation amounts follow the SM3 message schedule.
package sm3x_pkg;

    localparam int WORD_W = 32;

    // Rotation amounts used by the schedule and by P1
    localparam int ROT_TAP_NEAR  = 15;
    localparam int ROT_TAP_OLD   = 7;
    localparam int ROT_P1_A      = 15;
    localparam int ROT_P1_B      = 23;

    typedef logic [WORD_W-1:0] word_t;

    // Rotate a word left by a fixed amount in 1..WORD_W-1
    function automatic word_t rotl(input word_t x, input int unsigned n);
        return (x << n) | (x >> (WORD_W - n));
    endfunction

    // Permutation applied to the combined taps
    function automatic word_t p1_perm(input word_t x);
        return x ^ rotl(x, ROT_P1_A) ^ rotl(x, ROT_P1_B);
    endfunction

    // Next schedule word from the five window taps (ages 16, 9, 3, 13, 6)
    function automatic word_t expand_word(input word_t age16, input word_t age9,
                                          input word_t age3, input word_t age13,
                                          input word_t age6);
        return p1_perm(age16 ^ age9 ^ rotl(age3, ROT_TAP_NEAR))
               ^ rotl(age13, ROT_TAP_OLD) ^ age6;
    endfunction

endpackage

// File: rtl/sm3x_word_unpack.sv
// Module: splits a message block into big-endian words.
// Word 0 is taken from the most significant end of the block, so the first
// byte of the message becomes the top byte of word 0. Purely combinational.
module sm3x_word_unpack
    import sm3x_pkg::*;
#(
    parameter int NUM_WORDS = 16,
    localparam int BLOCK_W  = NUM_WORDS * WORD_W
) (
    input  logic [BLOCK_W-1:0]                block,
    output logic [NUM_WORDS-1:0][WORD_W-1:0]  words
);

    // One slice per word, highest slice first
    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_slice
        assign words[i] = block[BLOCK_W-1-i*WORD_W -: WORD_W];
    end

endmodule

// File: rtl/sm3x_window.sv
// Module: sliding window of schedule words.
// Entry k holds W[j+k] for the current round j. A load fills it with the block
// words; a step shifts it by one and appends the word produced from five taps.
// Assumes load and step are never asserted together.
module sm3x_window
    import sm3x_pkg::*;
#(
    parameter int NUM_WORDS = 16,
    parameter int LOOKAHEAD = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              load,
    input  logic                              step,
    input  logic [NUM_WORDS-1:0][WORD_W-1:0]  load_words,
    output word_t                             head_w,
    output word_t                             head_wp
);

    // Tap positions relative to the head for the word W[j+NUM_WORDS]
    localparam int TAP_AGE16 = 0;
    localparam int TAP_AGE9  = NUM_WORDS - 9;
    localparam int TAP_AGE3  = NUM_WORDS - 3;
    localparam int TAP_AGE13 = NUM_WORDS - 13;
    localparam int TAP_AGE6  = NUM_WORDS - 6;

    word_t win [NUM_WORDS];
    word_t tail_next;

    // Produce the word that enters at the tail on the next step
    always_comb begin
        tail_next = expand_word(win[TAP_AGE16], win[TAP_AGE9], win[TAP_AGE3],
                                win[TAP_AGE13], win[TAP_AGE6]);
    end

    // Clear, load or shift the window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_WORDS; k++) win[k] <= '0;
        end else if (load) begin
            for (int k = 0; k < NUM_WORDS; k++) win[k] <= load_words[k];
        end else if (step) begin
            for (int k = 0; k < NUM_WORDS - 1; k++) win[k] <= win[k+1];
            win[NUM_WORDS-1] <= tail_next;
        end
    end

    // Present the head word and its mix with the word LOOKAHEAD places ahead
    always_comb begin
        head_w  = win[0];
        head_wp = win[0] ^ win[LOOKAHEAD];
    end

endmodule

// File: rtl/sm3x_round_ctrl.sv
// Module: round sequencer for one block.
// Idle until a block is accepted, then counts the rounds as pairs are taken
// and returns to idle after the last one. A block is taken only when idle.
module sm3x_round_ctrl #(
    parameter int NUM_ROUNDS = 64,
    localparam int RND_W     = $clog2(NUM_ROUNDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             out_ready,
    output logic             in_ready,
    output logic             out_valid,
    output logic             load,
    output logic             step,
    output logic [RND_W-1:0] round
);

    localparam logic [RND_W-1:0] LAST_ROUND = RND_W'(NUM_ROUNDS - 1);

    logic busy;

    // Handshake decode
    always_comb begin
        in_ready  = !busy;
        out_valid = busy;
        load      = in_valid && !busy;
        step      = busy && out_ready;
    end

    // Track busy state and the round index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            round <= '0;
        end else if (load) begin
            busy  <= 1'b1;
            round <= '0;
        end else if (step) begin
            if (round == LAST_ROUND) begin
                busy  <= 1'b0;
                round <= '0;
            end else begin
                round <= round + 1'b1;
            end
        end
    end

endmodule

// File: rtl/sm3x_msg_expand.sv
// Module: SM3 message expansion unit (top).
// Accepts one 512-bit block and streams 64 (W, W') pairs, one per taken
// handshake, with the round index. Padding is done upstream.
module sm3x_msg_expand
    import sm3x_pkg::*;
#(
    parameter int NUM_WORDS  = 16,
    parameter int NUM_ROUNDS = 64,
    parameter int LOOKAHEAD  = 4,
    localparam int BLOCK_W   = NUM_WORDS * WORD_W,
    localparam int RND_W     = $clog2(NUM_ROUNDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [BLOCK_W-1:0] in_block,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [RND_W-1:0]   out_round,
    output logic [WORD_W-1:0]  out_w,
    output logic [WORD_W-1:0]  out_wp
);

    logic [NUM_WORDS-1:0][WORD_W-1:0] blk_words;
    logic load, step;

    // Block to words
    sm3x_word_unpack #(.NUM_WORDS(NUM_WORDS)) u_unpack (
        .block (in_block),
        .words (blk_words)
    );

    // Round sequencing and handshakes
    sm3x_round_ctrl #(.NUM_ROUNDS(NUM_ROUNDS)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .load      (load),
        .step      (step),
        .round     (out_round)
    );

    // Sliding schedule window
    sm3x_window #(.NUM_WORDS(NUM_WORDS), .LOOKAHEAD(LOOKAHEAD)) u_win (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .step       (step),
        .load_words (blk_words),
        .head_w     (out_w),
        .head_wp    (out_wp)
    );

endmodule

// File: rtl/sm3x_msg_expand_chk.sv
// Module: protocol and mixing checker bound to the expansion unit.
// Observes ports only; keeps a short history of taken pairs to relate W'
// to the word LOOKAHEAD rounds later.
module sm3x_msg_expand_chk #(
    parameter int NUM_WORDS  = 16,
    parameter int NUM_ROUNDS = 64,
    parameter int LOOKAHEAD  = 4,
    localparam int BLOCK_W   = NUM_WORDS * 32,
    localparam int RND_W     = $clog2(NUM_ROUNDS)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               in_ready,
    input logic [BLOCK_W-1:0] in_block,
    input logic               out_valid,
    input logic               out_ready,
    input logic [RND_W-1:0]   out_round,
    input logic [31:0]        out_w,
    input logic [31:0]        out_wp
);

    localparam logic [RND_W-1:0] LAST = RND_W'(NUM_ROUNDS - 1);

    logic take, accept;
    assign take   = out_valid && out_ready;
    assign accept = in_valid && in_ready;

    // Reset state
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && in_ready && out_round == '0));

    // Start of stream after acceptance
    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (out_valid && out_round == '0));

    // First word is the top of the accepted block
    p_first_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (out_w == $past(in_block[BLOCK_W-1 -: 32])));

    // Round index steps by one
    p_round_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (take && out_round != LAST) |=>
            (out_valid && out_round == RND_W'($past(out_round) + 1'b1)));

    // Hold under backpressure
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_w) && $stable(out_wp) && $stable(out_round)));

    // Idle after the last round
    p_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (take && out_round == LAST) |=> (!out_valid && in_ready));

    // Busy refuses new blocks
    p_busy_refuse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // History of W ^ W' (which should equal W[j+LOOKAHEAD])
    logic [31:0] hist [LOOKAHEAD];
    int unsigned taken_cnt;

    // Record taken pairs and compare the mix against later words
    always_ff @(posedge clk) begin
        if (!rst_n || accept) begin
            taken_cnt <= 0;
            for (int k = 0; k < LOOKAHEAD; k++) hist[k] <= '0;
        end else if (take) begin
            if (taken_cnt >= LOOKAHEAD) begin
                p_mixed_word_r5: assert (out_w == hist[LOOKAHEAD-1]);
            end
            hist[0] <= out_w ^ out_wp;
            for (int k = 1; k < LOOKAHEAD; k++) hist[k] <= hist[k-1];
            if (taken_cnt < LOOKAHEAD) taken_cnt <= taken_cnt + 1;
        end
    end

endmodule

bind sm3x_msg_expand sm3x_msg_expand_chk #(
    .NUM_WORDS (NUM_WORDS),
    .NUM_ROUNDS(NUM_ROUNDS),
    .LOOKAHEAD (LOOKAHEAD)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_block  (in_block),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_round (out_round),
    .out_w     (out_w),
    .out_wp    (out_wp)
);

// File: tb/sim_sm3x_msg_expand.sv
// Bench: directed scenarios against an independent schedule model.
module sim_sm3x_msg_expand;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [511:0] in_block = '0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [5:0]   out_round;
    logic [31:0]  out_w;
    logic [31:0]  out_wp;

    int checks = 0;
    int fails  = 0;
    logic [31:0] mw [0:67];

    always #4 clk = ~clk;

    sm3x_msg_expand u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_block(in_block), .out_valid(out_valid), .out_ready(out_ready),
        .out_round(out_round), .out_w(out_w), .out_wp(out_wp)
    );

    function automatic logic [31:0] rl(input logic [31:0] x, input int n);
        return (x << n) | (x >> (32 - n));
    endfunction

    function automatic logic [31:0] pp(input logic [31:0] x);
        return x ^ rl(x, 15) ^ rl(x, 23);
    endfunction

    // Reference schedule for one block
    task automatic build_model(input logic [511:0] blk);
        for (int i = 0; i < 16; i++) mw[i] = blk[511-32*i -: 32];
        for (int j = 16; j < 68; j++)
            mw[j] = pp(mw[j-16] ^ mw[j-9] ^ rl(mw[j-3], 15)) ^ rl(mw[j-13], 7) ^ mw[j-6];
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // R1: reset state
    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R1 out_valid", 32'(out_valid), 32'd0);
        chk("R1 in_ready", 32'(in_ready), 32'd1);
        chk("R1 out_round", 32'(out_round), 32'd0);
        rst_n = 1'b1;
    endtask

    // Full block stream; optional stalls (R7) and pushes while busy (R9)
    task automatic t_stream(input logic [511:0] blk, input bit stall, input bit poke);
        int idx = 0;
        int guard = 0;
        bit prev_stall = 0;
        build_model(blk);
        @(negedge clk);
        chk("R2 in_ready idle", 32'(in_ready), 32'd1);
        in_block = blk;
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        if (poke) in_block = ~blk; else in_valid = 1'b0;
        chk("R2 out_valid after accept", 32'(out_valid), 32'd1);
        while (idx < 64 && guard < 400) begin
            bit s;
            guard++;
            chk(prev_stall ? "R7 round held" : "R6 round", 32'(out_round), 32'(idx));
            chk(prev_stall ? "R7 W held" : (idx < 16 ? "R3 W" : "R4 W"), out_w, mw[idx]);
            chk(prev_stall ? "R7 Wp held" : "R5 Wp", out_wp, mw[idx] ^ mw[idx+4]);
            if (poke) begin
                chk("R9 in_ready busy", 32'(in_ready), 32'd0);
                if (idx >= 60) in_valid = 1'b0;
            end
            s = stall && !prev_stall && (idx % 5 == 2);
            out_ready = !s;
            prev_stall = s;
            @(posedge clk);
            if (!s) idx++;
            @(negedge clk);
        end
        out_ready = 1'b0;
        in_valid  = 1'b0;
        chk("R8 out_valid after 64", 32'(out_valid), 32'd0);
        chk("R8 in_ready after 64", 32'(in_ready), 32'd1);
        @(negedge clk);
        chk("R8 stays idle", 32'(out_valid), 32'd0);
    endtask

    // R10: reset in the middle of a stream, then a fresh block
    task automatic t_mid_reset(input logic [511:0] blk);
        @(negedge clk);
        in_block = blk;
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid  = 1'b0;
        out_ready = 1'b1;
        repeat (10) @(negedge clk);
        out_ready = 1'b0;
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R10 out_valid after reset", 32'(out_valid), 32'd0);
        chk("R10 in_ready after reset", 32'(in_ready), 32'd1);
        chk("R10 round after reset", 32'(out_round), 32'd0);
        t_stream(~blk, 1'b0, 1'b0);
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [511:0] b_abc, b_inc, b_alt;
        b_abc = {32'h61626380, 448'd0, 32'h00000018};
        for (int i = 0; i < 64; i++) b_inc[511-8*i -: 8] = 8'(i);
        b_alt = {16{32'hA5A5_5A5A}};
        repeat (2) @(posedge clk);
        t_reset();
        t_stream(b_abc, 1'b0, 1'b0);
        t_stream(b_inc, 1'b1, 1'b0);
        t_stream({512{1'b1}}, 1'b0, 1'b1);
        t_stream(b_alt, 1'b1, 1'b1);
        t_mid_reset(b_inc);
        t_reset();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule